// File: doc/BRIEF.md
# NOR Flash Write-Buffer Program Sequencer

This block moves a burst of data words into the write buffer of an asynchronous NOR flash and then tells the flash to commit the buffer. A requester gives it a start address and a word count with a one-clock start pulse. The block then takes the words from a ready/valid stream and produces every write cycle on the flash bus by itself. The bus has chip select, write enable and output enable, all active low, plus an address bus and a data bus driven by the block.

The flash sees this order of writes. First come two unlock writes at fixed command addresses. Next is a buffer-load command at the start address, then the word count minus one at the same address. After that, one write per data word goes to consecutive word addresses. The last write is a confirm command, and it goes to the address of the final data word, not to a command address.

Chip select stays low from the first unlock write to the end of the confirm write, including any time spent waiting for stream data. A word count the buffer cannot hold is refused at once. Completion is reported with a one-clock pulse.

Top module: `nor_wbuf_prog`

## Requirements
- R1: The first two write cycles of an accepted burst put 0xAA on address 0x555 and then 0x55 on address 0x2AA.
- R2: The third write cycle puts the buffer-load command 0x25 on the start address.
- R3: The fourth write cycle puts the word count minus one, zero-extended, on the start address.
- R4: Exactly word-count data cycles follow. The data cycle with index i writes the i-th accepted stream word to start address plus i, and stream words are taken in order.
- R5: The cycle after the last data cycle writes the confirm command 0x29 to the address of the last data word. Nothing is written after it.
- R6: A start pulse with a word count of zero, or one above BUF_WORDS, raises err for exactly the next clock. Chip select stays high and no write cycle is issued.
- R7: While the block waits for a stream word between data cycles, chip select stays low, in_ready is high and no write cycle is issued.
- R8: done is high for exactly one clock: the first clock after the confirm cycle, which is also the clock in which chip select returns high.
- R9: Each write-enable low pulse lasts exactly T_WP clocks, occurs only while chip select is low, and keeps address and data steady while write enable is low.
- R10: After reset, chip select, write enable and output enable are high, and in_ready, done and err are low. Output enable stays high at all times.
- R11: A start pulse that arrives while a burst is in progress has no effect on that burst.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | One-clock request to begin a burst |
| start_addr | input | AW | Word address of the first data word |
| word_count | input | CW | Number of data words, from 1 to BUF_WORDS |
| in_valid | input | 1 | Stream word present |
| in_data | input | DW | Stream word |
| in_ready | output | 1 | Block will take the stream word at this edge |
| fl_ce_n | output | 1 | Flash chip select, active low |
| fl_oe_n | output | 1 | Flash output enable, held high |
| fl_we_n | output | 1 | Flash write enable, active low |
| fl_addr | output | AW | Flash word address |
| fl_dout | output | DW | Flash write data |
| done | output | 1 | One-clock completion pulse |
| err | output | 1 | One-clock pulse for a refused word count |

## Verification
A wrong phase or remaining-count value shows up on the bus within one write cycle, four clocks at default timing. It appears as a write with the wrong address or data, a missing or extra data cycle, or a confirm aimed at the wrong address. A bad stream-wait state shows as in_ready high while write enable pulses, or as a write issued with no stream word. A fault in end-of-burst handling shows as done failing to line up with the rise of chip select.

// File: rtl/nor_wbuf_prog.sv
module nor_wbuf_prog #(
  parameter int AW        = 23,
  parameter int DW        = 16,
  parameter int BUF_WORDS = 32,
  parameter int T_SU      = 1,
  parameter int T_WP      = 2,
  parameter int T_H       = 1
) (
  input  logic                               clk,
  input  logic                               rst_n,
  input  logic                               start,
  input  logic [AW-1:0]                      start_addr,
  input  logic [$clog2(BUF_WORDS+1)-1:0]     word_count,
  input  logic                               in_valid,
  input  logic [DW-1:0]                      in_data,
  output logic                               in_ready,
  output logic                               fl_ce_n,
  output logic                               fl_oe_n,
  output logic                               fl_we_n,
  output logic [AW-1:0]                      fl_addr,
  output logic [DW-1:0]                      fl_dout,
  output logic                               done,
  output logic                               err
);
  localparam int CW  = $clog2(BUF_WORDS+1);
  localparam int LEN = T_SU + T_WP + T_H;
  localparam int LW  = $clog2(LEN+1);
  localparam logic [AW-1:0] ADR_UNLK1 = AW'(12'h555);
  localparam logic [AW-1:0] ADR_UNLK2 = AW'(12'h2AA);
  localparam logic [DW-1:0] DAT_UNLK1 = DW'(8'hAA);
  localparam logic [DW-1:0] DAT_UNLK2 = DW'(8'h55);
  localparam logic [DW-1:0] CMD_LOAD  = DW'(8'h25);
  localparam logic [DW-1:0] CMD_CONF  = DW'(8'h29);

  typedef enum logic [1:0] {S_IDLE, S_BUS, S_WAIT} st_t;
  typedef enum logic [2:0] {P_UNLK1, P_UNLK2, P_LOAD, P_CNT, P_DATA, P_CONF} ph_t;

  st_t           st;
  ph_t           ph;
  logic [LW-1:0] tick;
  logic [AW-1:0] addr_q, base_q, last_q;
  logic [DW-1:0] dout_q;
  logic [CW-1:0] remain;
  logic          done_q, err_q;

  wire bad_cnt = (word_count == '0) || (word_count > CW'(BUF_WORDS));
  wire cyc_end = (st == S_BUS) && (tick == LW'(LEN-1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      ph     <= P_UNLK1;
      tick   <= '0;
      addr_q <= '0;
      base_q <= '0;
      last_q <= '0;
      dout_q <= '0;
      remain <= '0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          if (bad_cnt) begin
            err_q <= 1'b1;
          end else begin
            base_q <= start_addr;
            remain <= word_count;
            addr_q <= ADR_UNLK1;
            dout_q <= DAT_UNLK1;
            ph     <= P_UNLK1;
            tick   <= '0;
            st     <= S_BUS;
          end
        end
        S_WAIT: if (in_valid) begin
          dout_q <= in_data;
          last_q <= addr_q;
          tick   <= '0;
          st     <= S_BUS;
        end
        S_BUS: if (!cyc_end) begin
          tick <= tick + 1'b1;
        end else begin
          tick <= '0;
          case (ph)
            P_UNLK1: begin ph <= P_UNLK2; addr_q <= ADR_UNLK2; dout_q <= DAT_UNLK2; end
            P_UNLK2: begin ph <= P_LOAD;  addr_q <= base_q;    dout_q <= CMD_LOAD;  end
            P_LOAD:  begin ph <= P_CNT;   dout_q <= DW'(remain - 1'b1);              end
            P_CNT:   begin ph <= P_DATA;  st <= S_WAIT;                              end
            P_DATA: begin
              remain <= remain - 1'b1;
              if (remain == CW'(1)) begin
                ph     <= P_CONF;
                addr_q <= last_q;
                dout_q <= CMD_CONF;
              end else begin
                addr_q <= addr_q + 1'b1;
                st     <= S_WAIT;
              end
            end
            default: begin
              st     <= S_IDLE;
              done_q <= 1'b1;
            end
          endcase
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  assign in_ready = (st == S_WAIT);
  assign fl_ce_n  = (st == S_IDLE);
  assign fl_oe_n  = 1'b1;
  assign fl_we_n  = !((st == S_BUS) && (tick >= LW'(T_SU)) && (tick < LW'(T_SU + T_WP)));
  assign fl_addr  = addr_q;
  assign fl_dout  = dout_q;
  assign done     = done_q;
  assign err      = err_q;

  AST_WE_UNDER_CE: assert property (@(posedge clk) disable iff (!rst_n) !fl_we_n |-> !fl_ce_n); // R9
  AST_WE_LOW_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!fl_we_n && $past(!fl_we_n)) |-> ($stable(fl_addr) && $stable(fl_dout))); // R9
  AST_WAIT_HOLDS_CE: assert property (@(posedge clk) disable iff (!rst_n) in_ready |-> (!fl_ce_n && fl_we_n)); // R7
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) done |=> !done); // R8
  AST_DONE_AT_CE_RISE: assert property (@(posedge clk) disable iff (!rst_n) done |-> (fl_ce_n && $past(!fl_ce_n))); // R8
  AST_ERR_NO_BUS: assert property (@(posedge clk) disable iff (!rst_n) err |-> (fl_ce_n && !$past(!fl_ce_n))); // R6
  AST_OE_HIGH: assert property (@(posedge clk) disable iff (!rst_n) fl_oe_n); // R10
endmodule

// File: tb/nor_wbuf_prog_tb.sv
module nor_wbuf_prog_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 23, DW = 16, BUF_WORDS = 32, T_SU = 1, T_WP = 2, T_H = 1;
  localparam int CW = $clog2(BUF_WORDS+1);
  localparam int LEN = T_SU + T_WP + T_H;

  logic clk = 1'b0, rst_n = 1'b0, start = 1'b0, in_valid = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [CW-1:0] word_count = '0;
  logic [DW-1:0] in_data = '0;
  logic in_ready, fl_ce_n, fl_oe_n, fl_we_n, done, err;
  logic [AW-1:0] fl_addr;
  logic [DW-1:0] fl_dout;

  int nchk = 0, nerr = 0;
  int wr_n = 0;
  logic [AW-1:0] log_a [64];
  logic [DW-1:0] log_d [64];
  int lowlen = 0;
  logic stab_ok, cap_ce;
  logic [AW-1:0] cap_a;
  logic [DW-1:0] cap_d;

  always #(CLK_PERIOD/2) clk = ~clk;

  nor_wbuf_prog #(.AW(AW), .DW(DW), .BUF_WORDS(BUF_WORDS), .T_SU(T_SU), .T_WP(T_WP), .T_H(T_H)) dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr), .word_count(word_count),
    .in_valid(in_valid), .in_data(in_data), .in_ready(in_ready), .fl_ce_n(fl_ce_n), .fl_oe_n(fl_oe_n),
    .fl_we_n(fl_we_n), .fl_addr(fl_addr), .fl_dout(fl_dout), .done(done), .err(err));

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    nchk++;
    if (!ok) begin
      nerr++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      if (!fl_we_n) begin
        if (lowlen == 0) begin
          cap_a = fl_addr; cap_d = fl_dout; stab_ok = 1'b1; cap_ce = 1'b1;
        end else if (fl_addr !== cap_a || fl_dout !== cap_d) stab_ok = 1'b0;
        if (fl_ce_n) cap_ce = 1'b0;
        lowlen++;
      end else if (lowlen != 0) begin
        chk(lowlen == T_WP && stab_ok && cap_ce, "R9 write pulse", lowlen, T_WP);
        if (wr_n < 64) begin log_a[wr_n] = cap_a; log_d[wr_n] = cap_d; end
        wr_n++;
        lowlen = 0;
      end
    end
  end

  function automatic logic [DW-1:0] dval(input logic [AW-1:0] a, input int i);
    return DW'(16'hC35A ^ (a[15:0] + 16'(i) * 16'h0101));
  endfunction

  function automatic longint pk(input logic [AW-1:0] a, input logic [DW-1:0] d);
    return (longint'(a) << 16) | longint'(d);
  endfunction

  task automatic wait_idle();
    int g = 0;
    while (!fl_ce_n && g < 2000) begin @(negedge clk); g++; end
  endtask

  task automatic run_burst(input logic [AW-1:0] a, input int n, input int stall_after, input bit poke, input string tag);
    logic r;
    logic pc;
    int g;
    bit ce_ok;
    wait_idle();
    wr_n = 0;
    start_addr = a; word_count = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < n; i++) begin
      in_valid = 1'b1; in_data = dval(a, i);
      g = 0;
      do begin r = in_ready; @(negedge clk); g++; end while (!r && g < 500);
      in_valid = 1'b0;
      if (poke && i == 0) begin
        start_addr = a + 23'd100; word_count = CW'(3); start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
      if (i == stall_after) begin
        ce_ok = 1'b1;
        for (int k = 0; k < 3*LEN+2; k++) begin
          @(negedge clk);
          if (fl_ce_n) ce_ok = 1'b0;
        end
        chk(ce_ok, {"R7 chip select held in stall ", tag}, ce_ok, 1);
        chk(in_ready == 1'b1, {"R7 ready during stall ", tag}, in_ready, 1);
        chk(wr_n == 4 + i + 1, {"R7 no writes while stalled ", tag}, wr_n, 4 + i + 1);
      end
    end
    g = 0;
    pc = fl_ce_n;
    while (!done && g < 2000) begin pc = fl_ce_n; @(negedge clk); g++; end
    chk(done && fl_ce_n && !pc, {"R8 done aligned with ce rise ", tag}, {done, fl_ce_n, pc}, 3'b110);
    @(negedge clk);
    chk(!done, {"R8 done single clock ", tag}, done, 0);
    chk(wr_n == n + 5, {"R4 write count ", tag}, wr_n, n + 5);
    if (wr_n == n + 5) begin
      chk(log_a[0] == 23'h555 && log_d[0] == 16'hAA, {"R1 unlock one ", tag}, pk(log_a[0], log_d[0]), pk(23'h555, 16'hAA));
      chk(log_a[1] == 23'h2AA && log_d[1] == 16'h55, {"R1 unlock two ", tag}, pk(log_a[1], log_d[1]), pk(23'h2AA, 16'h55));
      chk(log_a[2] == a && log_d[2] == 16'h25, {"R2 load command ", tag}, pk(log_a[2], log_d[2]), pk(a, 16'h25));
      chk(log_a[3] == a && log_d[3] == DW'(n - 1), {"R3 count word ", tag}, pk(log_a[3], log_d[3]), pk(a, DW'(n - 1)));
      for (int i = 0; i < n; i++)
        chk(log_a[4+i] == a + AW'(i) && log_d[4+i] == dval(a, i), {"R4 data cycle ", tag},
            pk(log_a[4+i], log_d[4+i]), pk(a + AW'(i), dval(a, i)));
      chk(log_a[n+4] == a + AW'(n - 1) && log_d[n+4] == 16'h29, {"R5 confirm at last address ", tag},
          pk(log_a[n+4], log_d[n+4]), pk(a + AW'(n - 1), 16'h29));
    end
    if (poke) begin
      repeat (3*LEN) @(negedge clk);
      chk(fl_ce_n && wr_n == n + 5, "R11 start while busy ignored", wr_n, n + 5);
    end
  endtask

  task automatic bad_start(input int n);
    bit quiet = 1'b1;
    wait_idle();
    wr_n = 0;
    start_addr = 23'h000040; word_count = CW'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(err == 1'b1, "R6 err raised", err, 1);
    chk(fl_ce_n && !in_ready, "R6 no bus on refusal", {fl_ce_n, in_ready}, 2'b10);
    @(negedge clk);
    chk(err == 1'b0, "R6 err one clock", err, 0);
    for (int k = 0; k < 8; k++) begin
      if (!fl_ce_n) quiet = 1'b0;
      @(negedge clk);
    end
    chk(quiet && wr_n == 0, "R6 no write cycles", wr_n, 0);
  endtask

  task automatic reset_check();
    chk(fl_ce_n && fl_we_n && fl_oe_n, "R10 bus idle after reset", {fl_ce_n, fl_we_n, fl_oe_n}, 3'b111);
    chk(!in_ready && !done && !err, "R10 flags low after reset", {in_ready, done, err}, 0);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nerr++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    reset_check();
    run_burst(23'h000100, 4, -1, 1'b0, "basic");
    run_burst(23'h7FFFF0, 1, -1, 1'b0, "single word");
    run_burst(23'h001234, BUF_WORDS, -1, 1'b0, "full buffer");
    run_burst(23'h040000, 6, 2, 1'b0, "stalled");
    run_burst(23'h000800, 4, -1, 1'b1, "poked");
    bad_start(0);
    bad_start(BUF_WORDS + 1);
    run_burst(23'h0002A0, 3, 0, 1'b0, "after refusal");
    chk(fl_oe_n == 1'b1, "R10 output enable high", fl_oe_n, 1);
    summary();
    $finish;
  end
endmodule